// File: doc/BRIEF.md
# Shared-Fetch Thread Selector with Stack-Depth Priority

This block chooses which program counter a shared instruction-fetch front end serves in a core that runs several hardware threads. Each thread presents its private program counter, its stack pointer and an active flag. Every cycle the block picks one winning thread and outputs that thread's PC as the fetch address. It also outputs a grant mask that names every active thread whose PC equals the chosen one, so threads that have reconverged share one fetch.

By default the priority key is the stack pointer joined above the program counter, compared as a single unsigned number. Stacks grow downward, so a smaller stack pointer means a deeper call level. That level is served first, which lets threads that sit in a called function catch up with threads still in the caller. A mode pin switches to plain lowest-PC priority, with the stack pointer left out of the compare.

The result is registered, so it appears one cycle after the inputs are sampled. The output is a stream without back-pressure: there is no ready pin. The consumer must take the selection on every cycle in which the valid flag is high, and the block computes a fresh selection on every clock.

Top module: `minsp_fetch_sel`

## Requirements
- R1: While no thread is active (active_in all zeros), the next cycle shows valid low, grant all zeros and sel_pc zero.
- R2: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge. A new input set is visible after exactly one edge.
- R3: With mode_pc_only = 0, the winner is the active thread with the smallest unsigned key {SP, PC}, where the 64-bit SP is the upper half. sel_pc is that thread's PC. This holds across the full 64-bit range.
- R4: With mode_pc_only = 0, among active threads that have equal SP, the one with the smaller PC wins.
- R5: With mode_pc_only = 1, the winner is the active thread with the smallest PC, and SP values have no effect on sel_pc or grant.
- R6: grant bit i (thread i) is set exactly when thread i is active and its PC equals sel_pc. This holds even when its SP differs from the winner's SP.
- R7: An inactive thread never wins and is never granted, even if its key is the smallest or its PC matches sel_pc.
- R8: When two active threads have fully equal keys, sel_pc is their common PC and both grant bits are set.
- R9: A synchronous active-low reset (rst_n = 0 at a rising edge) clears valid, grant and sel_pc at that edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_pc_only | input | 1 | 0: priority by {SP,PC}; 1: priority by PC only |
| active_in | input | N | Bit i set when thread i competes for fetch |
| pc_in | input | N*PCW | Thread i PC in bits [i*PCW +: PCW] |
| sp_in | input | N*SPW | Thread i SP in bits [i*SPW +: SPW] |
| valid | output | 1 | A selection is present this cycle |
| sel_pc | output | PCW | Selected fetch program counter |
| grant | output | N | Threads that receive the fetched instruction |

## Verification
The only state is the output register, so a fault in the compare tree or in the match logic shows at the ports on the very next cycle. It appears as a sel_pc that is not the minimum key, a grant bit missing for a thread with the same PC, or a bit set for an idle thread. The reference model in the bench recomputes the minimum by a linear scan on every cycle. Many cycles use deliberately colliding SP and PC values, so a wrong tie rule, a key narrowed by even one bit, or a mode that leaks SP into the compare is found within a few cycles.

// File: rtl/minsp_fetch_sel_pkg.sv
package minsp_fetch_sel_pkg;

  typedef enum logic {
    PRIO_STACK_THEN_PC = 1'b0,
    PRIO_PC_ONLY       = 1'b1
  } prio_mode_e;

  function automatic int tree_levels(input int threads);
    return (threads > 1) ? $clog2(threads) : 1;
  endfunction

endpackage

// File: rtl/minsp_key_gen.sv
module minsp_key_gen
  import minsp_fetch_sel_pkg::*;
#(
  parameter int N   = 8,
  parameter int PCW = 64,
  parameter int SPW = 64,
  localparam int KW = PCW + SPW
) (
  input  prio_mode_e         mode,
  input  logic [N*PCW-1:0]   pc_flat,
  input  logic [N*SPW-1:0]   sp_flat,
  output logic [N*KW-1:0]    key_flat
);

  // Key per thread: stack pointer on top, PC below; SP masked in PC-only mode.
  for (genvar t = 0; t < N; t++) begin : g_thr
    logic [SPW-1:0] sp_eff;
    assign sp_eff = (mode == PRIO_PC_ONLY) ? '0 : sp_flat[t*SPW +: SPW];
    assign key_flat[t*KW +: KW] = {sp_eff, pc_flat[t*PCW +: PCW]};
  end

endmodule

// File: rtl/minsp_min_tree.sv
module minsp_min_tree
  import minsp_fetch_sel_pkg::*;
#(
  parameter int N   = 8,
  parameter int PCW = 64,
  parameter int KW  = 128,
  localparam int LV = tree_levels(N),
  localparam int P  = 1 << LV
) (
  input  logic [N-1:0]      cand_vld,
  input  logic [N*KW-1:0]   key_flat,
  output logic              win_vld,
  output logic [PCW-1:0]    win_pc
);

  // Tournament tree; the lower-index side wins equal keys.
  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    localparam int W = P >> l;
    logic [W-1:0]         v;
    logic [W-1:0][KW-1:0] k;

    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < W; j++) begin : g_in
        if (j < N) begin : g_real
          assign v[j] = cand_vld[j];
          assign k[j] = key_flat[j*KW +: KW];
        end else begin : g_pad
          assign v[j] = 1'b0;
          assign k[j] = '0;
        end
      end
    end else begin : g_node
      for (genvar j = 0; j < W; j++) begin : g_cmp
        logic take_lo;
        assign take_lo = g_lvl[l-1].v[2*j] &&
                         (!g_lvl[l-1].v[2*j+1] ||
                          (g_lvl[l-1].k[2*j] <= g_lvl[l-1].k[2*j+1]));
        assign v[j] = g_lvl[l-1].v[2*j] | g_lvl[l-1].v[2*j+1];
        assign k[j] = take_lo ? g_lvl[l-1].k[2*j] : g_lvl[l-1].k[2*j+1];
      end
    end
  end

  assign win_vld = g_lvl[LV].v[0];
  assign win_pc  = g_lvl[LV].k[0][PCW-1:0];

endmodule

// File: rtl/minsp_grant_match.sv
module minsp_grant_match #(
  parameter int N   = 8,
  parameter int PCW = 64
) (
  input  logic [N-1:0]      active,
  input  logic [N*PCW-1:0]  pc_flat,
  input  logic              win_vld,
  input  logic [PCW-1:0]    win_pc,
  output logic [N-1:0]      match
);

  for (genvar t = 0; t < N; t++) begin : g_thr
    assign match[t] = win_vld && active[t] && (pc_flat[t*PCW +: PCW] == win_pc);
  end

endmodule

// File: rtl/minsp_fetch_sel.sv
module minsp_fetch_sel
  import minsp_fetch_sel_pkg::*;
#(
  parameter int N   = 8,
  parameter int PCW = 64,
  parameter int SPW = 64,
  localparam int KW = PCW + SPW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_pc_only,
  input  logic [N-1:0]     active_in,
  input  logic [N*PCW-1:0] pc_in,
  input  logic [N*SPW-1:0] sp_in,
  output logic             valid,
  output logic [PCW-1:0]   sel_pc,
  output logic [N-1:0]     grant
);

  prio_mode_e          mode;
  logic [N*KW-1:0]     keys;
  logic                w_vld;
  logic [PCW-1:0]      w_pc;
  logic [N-1:0]        w_match;

  assign mode = prio_mode_e'(mode_pc_only);

  minsp_key_gen #(.N(N), .PCW(PCW), .SPW(SPW)) u_keys (
    .mode     (mode),
    .pc_flat  (pc_in),
    .sp_flat  (sp_in),
    .key_flat (keys)
  );

  minsp_min_tree #(.N(N), .PCW(PCW), .KW(KW)) u_tree (
    .cand_vld (active_in),
    .key_flat (keys),
    .win_vld  (w_vld),
    .win_pc   (w_pc)
  );

  minsp_grant_match #(.N(N), .PCW(PCW)) u_match (
    .active  (active_in),
    .pc_flat (pc_in),
    .win_vld (w_vld),
    .win_pc  (w_pc),
    .match   (w_match)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      sel_pc <= '0;
      grant  <= '0;
    end else begin
      valid  <= w_vld;
      sel_pc <= w_vld ? w_pc : '0;
      grant  <= w_match;
    end
  end

endmodule

// File: rtl/minsp_fetch_sel_chk.sv
module minsp_fetch_sel_chk #(
  parameter int N   = 8,
  parameter int PCW = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     active_in,
  input logic [N*PCW-1:0] pc_in,
  input logic             valid,
  input logic [PCW-1:0]   sel_pc,
  input logic [N-1:0]     grant
);

  // R1: idle output carries no grant
  p_idle_no_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (grant == '0));

  // R2: valid follows presence of any active thread one edge earlier
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (valid == $past(|active_in)));

  // R6: a valid selection always serves at least the winner
  p_grant_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (grant != '0));

  // R7: no grant to a thread that was idle
  p_grant_only_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((grant & ~$past(active_in)) == '0));

  // R9: the edge after reset leaves outputs cleared
  p_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!valid && grant == '0 && sel_pc == '0));

  for (genvar t = 0; t < N; t++) begin : g_thr
    // R6: a granted thread had the selected PC
    p_granted_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      grant[t] |-> (sel_pc == $past(pc_in[t*PCW +: PCW])));
    // R6: an active thread with the selected PC is granted
    p_match_granted_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && valid && $past(active_in[t]) &&
       ($past(pc_in[t*PCW +: PCW]) == sel_pc)) |-> grant[t]);
  end

endmodule

bind minsp_fetch_sel minsp_fetch_sel_chk #(.N(N), .PCW(PCW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .active_in (active_in),
  .pc_in     (pc_in),
  .valid     (valid),
  .sel_pc    (sel_pc),
  .grant     (grant)
);

// File: tb/minsp_fetch_sel_tb_top.sv
module minsp_fetch_sel_tb_top;
  localparam int  N   = 8;
  localparam int  PCW = 64;
  localparam int  SPW = 64;
  localparam time CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             mode_pc_only;
  logic [N-1:0]     active_in;
  logic [N*PCW-1:0] pc_in;
  logic [N*SPW-1:0] sp_in;
  logic             valid;
  logic [PCW-1:0]   sel_pc;
  logic [N-1:0]     grant;

  int checks = 0;
  int errors = 0;

  logic [PCW-1:0] t_pc [N];
  logic [SPW-1:0] t_sp [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  minsp_fetch_sel #(.N(N), .PCW(PCW), .SPW(SPW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_pc_only (mode_pc_only),
    .active_in    (active_in),
    .pc_in        (pc_in),
    .sp_in        (sp_in),
    .valid        (valid),
    .sel_pc       (sel_pc),
    .grant        (grant)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive one input set at a falling edge, let one rising edge pass, compare.
  task automatic run(input logic m, input logic [N-1:0] a, input string tag);
    logic           ev;
    logic [63:0]    epc;
    logic [N-1:0]   eg;
    logic [127:0]   best;
    logic [127:0]   key;
    mode_pc_only = m;
    active_in    = a;
    for (int i = 0; i < N; i++) begin
      pc_in[i*PCW +: PCW] = t_pc[i];
      sp_in[i*SPW +: SPW] = t_sp[i];
    end
    ev = 1'b0; best = '0; epc = '0; eg = '0;
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (a[i]) begin
          key = m ? {64'd0, t_pc[i]} : {t_sp[i], t_pc[i]};
          if (!ev || key < best) begin
            best = key;
            ev = 1'b1;
          end
        end
      end
      epc = best[63:0];
      for (int i = 0; i < N; i++) eg[i] = ev && a[i] && (t_pc[i] == epc);
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "valid", {63'd0, valid}, {63'd0, ev});
    chk(tag, "sel_pc", sel_pc, epc);
    chk(tag, "grant", {{(64-N){1'b0}}, grant}, {{(64-N){1'b0}}, eg});
  endtask

  task automatic fill_default();
    for (int i = 0; i < N; i++) begin
      t_pc[i] = 64'h4000_0000 + 64'(i) * 64'h100;
      t_sp[i] = 64'h7fff_0000 - 64'(i) * 64'h10;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    mode_pc_only = 1'b0;
    active_in = '0;
    pc_in = '0;
    sp_in = '0;
    fill_default();
    @(negedge clk);
    run(1'b0, 8'hFF, "R9_in_reset");
    run(1'b0, 8'h0F, "R1_reset_state");
    rst_n = 1'b1;

    // R1: nothing active
    run(1'b0, 8'h00, "R1");

    // R3: deeper stack beats lower PC
    fill_default();
    t_pc[0] = 64'h100; t_sp[0] = 64'h9000;
    t_pc[2] = 64'h900; t_sp[2] = 64'h8000;
    run(1'b0, 8'b0000_0101, "R3");

    // R5: same inputs, PC-only mode picks lower PC
    run(1'b1, 8'b0000_0101, "R5");

    // R4: equal SP, smaller PC wins
    fill_default();
    t_pc[3] = 64'h500; t_sp[3] = 64'h8000;
    t_pc[6] = 64'h480; t_sp[6] = 64'h8000;
    run(1'b0, 8'b0100_1000, "R4");

    // R6: same PC, different SP, both granted
    fill_default();
    t_pc[1] = 64'h100; t_sp[1] = 64'h8000;
    t_pc[5] = 64'h100; t_sp[5] = 64'h9000;
    t_pc[3] = 64'h200; t_sp[3] = 64'hA000;
    run(1'b0, 8'b0010_1010, "R6");

    // R7: inactive thread with lowest key and a matching PC is ignored
    fill_default();
    t_pc[0] = 64'h10;  t_sp[0] = 64'h10;
    t_pc[4] = 64'h300; t_sp[4] = 64'h20;
    t_pc[7] = 64'h300; t_sp[7] = 64'h500;
    run(1'b0, 8'b1000_0000, "R7");

    // R8: full tie between threads 6 and 7
    fill_default();
    t_pc[6] = 64'h777; t_sp[6] = 64'h1000;
    t_pc[7] = 64'h777; t_sp[7] = 64'h1000;
    run(1'b0, 8'b1100_0001, "R8");

    // R3: full-width extremes
    fill_default();
    t_pc[2] = 64'hFFFF_FFFF_FFFF_FFFF; t_sp[2] = 64'h0;
    t_pc[5] = 64'h0;                   t_sp[5] = 64'h1;
    run(1'b0, 8'b0010_0100, "R3_wide");
    run(1'b1, 8'b0010_0100, "R5_wide");

    // R2: back-to-back changes each visible after one edge
    fill_default();
    run(1'b0, 8'h01, "R2_a");
    run(1'b0, 8'h80, "R2_b");
    run(1'b0, 8'h00, "R2_c");

    // R9: reset in the middle of operation
    fill_default();
    run(1'b0, 8'hFF, "R9_pre");
    rst_n = 1'b0;
    run(1'b0, 8'hFF, "R9");
    rst_n = 1'b1;
    run(1'b0, 8'hFF, "R9_post");

    // Dense collisions of SP and PC values
    for (int c = 0; c < 400; c++) begin
      logic m;
      for (int i = 0; i < N; i++) begin
        t_pc[i] = 64'h1000 + 64'(4 * ($urandom % 4));
        t_sp[i] = 64'h7000_0000 - 64'(16 * ($urandom % 3));
      end
      m = (($urandom % 4) == 0);
      run(m, 8'($urandom), m ? "R5_rand" : "R3_rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule